// File: doc/BRIEF.md
# Strobed Handshake Port Controller

This block puts two 8-bit parallel ports, group A and group B, behind a small CPU register interface. Each group runs either as a latched output port or as a latched input port. Full-buffer flags, enables and interrupt requests sit at fixed bit positions of an 8-bit control/status image. On the output side, a CPU write latches the byte onto the pins and pulls an active-low "output full" line. The peripheral answers with an active-low acknowledge pulse, and the rising edge of that pulse releases the buffer. On the input side, an active-low strobe from the peripheral captures the pins into an input latch and raises "input full". The latch is then held until the CPU reads it.

Each group has an interrupt request. It is raised by the event that completes a transfer, but only when the group's enable bit is set. The enable bits are written with a single-bit set/reset command. Peripheral handshake lines are asynchronous and pass through a synchronizer of parameterised depth before their edges are detected.

Top module: `hs_port_ctl`

## Requirements
- R1: After reset, both groups are output ports, all latches are 0, enables and interrupts are clear, `a_obf_n`=1, `b_flag`=1, `a_ibf`=0, and the status register reads 0x82.
- R2: Address map: 0 = group A data, 1 = group B data, 2 = status, 3 = command. A command with bit7=1 is a mode word. In a mode word, bit4 selects group A input (1) or output (0) and bit1 does the same for group B. A mode word clears both groups' latches, full flags, enables and interrupts. A command with bit7=0 is a bit set/reset: bits[3:1] give a position and bit0 gives the value. Only position 6 (A enable, A output), position 4 (A enable, A input) and position 2 (B enable) have an effect; all other positions are ignored.
- R3: In output mode, a data write puts the byte on the group's output pins. From the next cycle, output-full is asserted (`a_obf_n`=0, or `b_flag`=0) and the group's interrupt is cleared.
- R4: In output mode, the rising edge of the acknowledge line while output-full is asserted releases output-full. It also sets the interrupt if the group's enable is set.
- R5: In input mode, a falling strobe while input-full is clear loads the input pins into the latch and sets input-full (`a_ibf`=1, or `b_flag`=1). It also sets the interrupt if the enable is set.
- R6: Strobes that arrive while input-full is set leave the latch unchanged.
- R7: In input mode, a CPU read of the data address returns the latch and clears input-full and the interrupt.
- R8: An interrupt is never raised while the group's enable is clear.
- R9: Status bits: bit7 = A not-full in output mode (0 in input mode), bit6 = A enable in output mode, bit5 = A full in input mode, bit4 = A enable in input mode, bit3 = A interrupt, bit2 = B enable, bit1 = B not-full in output mode or B full in input mode, bit0 = B interrupt.
- R10: A data write to a group in input mode is ignored, so its output pins keep their value.
- R11: Clearing a group's enable through the bit set/reset command also drops a pending interrupt of that group.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | 2 | Register address |
| cpu_wr | input | 1 | Write strobe, one cycle per access |
| cpu_rd | input | 1 | Read strobe, one cycle per access |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Read data (combinational from address) |
| a_pins_in | input | 8 | Group A input pins |
| a_pins_out | output | 8 | Group A output latch |
| b_pins_in | input | 8 | Group B input pins |
| b_pins_out | output | 8 | Group B output latch |
| a_stb_n | input | 1 | Group A strobe, active low |
| a_ack_n | input | 1 | Group A acknowledge, active low |
| b_hs_n | input | 1 | Group B strobe or acknowledge, active low |
| a_obf_n | output | 1 | Group A output full, active low |
| a_ibf | output | 1 | Group A input full |
| a_irq | output | 1 | Group A interrupt request |
| b_flag | output | 1 | Group B full flag (active low in output mode, high in input mode) |
| b_irq | output | 1 | Group B interrupt request |

## Verification
Output transfers are tried with several bytes, including all-zeros, all-ones and alternating patterns, on both groups, each with the enable set and with it clear. This separates data-path faults from flag faults and shows whether the interrupt follows the enable rather than the acknowledge alone. Input transfers send a second strobe with different pin data while the latch is full, which exposes a latch that overwrites. A group is also run with its enable clear to tell the interrupt path apart from the full flag. Directed cases then cover writes to an input-mode port, set/reset commands aimed at unused positions, clearing an enable while an interrupt is pending, and a reset applied during a pending transfer.

// File: rtl/hs_port_pkg.sv
package hs_port_pkg;
  localparam int unsigned DW = 8;

  typedef enum logic {DIR_OUT = 1'b0, DIR_IN = 1'b1} dir_e;

  localparam logic [1:0] ADDR_A    = 2'd0;
  localparam logic [1:0] ADDR_B    = 2'd1;
  localparam logic [1:0] ADDR_STAT = 2'd2;
  localparam logic [1:0] ADDR_CMD  = 2'd3;

  localparam int unsigned MODE_BIT  = 7;
  localparam int unsigned DIR_A_BIT = 4;
  localparam int unsigned DIR_B_BIT = 1;

  localparam logic [2:0] POS_A_OUT_EN = 3'd6;
  localparam logic [2:0] POS_A_IN_EN  = 3'd4;
  localparam logic [2:0] POS_B_EN     = 3'd2;

  // Enable position of group A depends on its direction.
  function automatic logic [2:0] a_en_pos(dir_e d);
    return (d == DIR_IN) ? POS_A_IN_EN : POS_A_OUT_EN;
  endfunction

  // Builds the status image from both groups' state.
  function automatic logic [7:0] pack_status(
      dir_e da, logic fa, logic ea, logic ia,
      dir_e db, logic fb, logic eb, logic ib);
    logic [7:0] s;
    s = '0;
    if (da == DIR_OUT) begin
      s[7] = ~fa;
      s[6] = ea;
    end else begin
      s[5] = fa;
      s[4] = ea;
    end
    s[3] = ia;
    s[2] = eb;
    s[1] = (db == DIR_OUT) ? ~fb : fb;
    s[0] = ib;
    return s;
  endfunction
endpackage

// File: rtl/hs_port_sync.sv
module hs_port_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic level,
  output logic fall,
  output logic rise
);
  logic [STAGES-1:0] chain;
  logic              prev;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain <= '1;
        else        chain <= async_in;
    end else begin : g_multi
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain <= '1;
        else        chain <= {chain[STAGES-2:0], async_in};
    end
  endgenerate

  assign level = chain[STAGES-1];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) prev <= 1'b1;
    else        prev <= level;

  assign fall = prev & ~level;
  assign rise = ~prev & level;

  // R5: an edge is reported for exactly one cycle
  a_r5_single_fall: assert property (@(posedge clk) disable iff (!rst_n)
    fall |=> !fall);
endmodule

// File: rtl/hs_port_group.sv
module hs_port_group
  import hs_port_pkg::*;
#(
  parameter int unsigned W = DW
) (
  input  logic         clk,
  input  logic         rst_n,
  input  dir_e         dir,
  input  logic         cfg_clr,
  input  logic         inte_set,
  input  logic         inte_clr,
  input  logic         cpu_wr,
  input  logic         cpu_rd,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] pins,
  input  logic         hs_fall,
  input  logic         hs_rise,
  output logic [W-1:0] dout,
  output logic [W-1:0] din,
  output logic         full,
  output logic         intr,
  output logic         inte
);
  logic load_ev, rel_ev, out_wr, in_rd;

  assign out_wr  = (dir == DIR_OUT) & cpu_wr;
  assign in_rd   = (dir == DIR_IN) & cpu_rd;
  assign load_ev = (dir == DIR_IN) & hs_fall & ~full;
  assign rel_ev  = (dir == DIR_OUT) & hs_rise & full & ~cpu_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout <= '0; din <= '0; full <= 1'b0; intr <= 1'b0; inte <= 1'b0;
    end else if (cfg_clr) begin
      dout <= '0; din <= '0; full <= 1'b0; intr <= 1'b0; inte <= 1'b0;
    end else begin
      if (inte_set) inte <= 1'b1;
      if (inte_clr) inte <= 1'b0;
      if (out_wr) begin
        dout <= wdata;
        full <= 1'b1;
        intr <= 1'b0;
      end else if (rel_ev) begin
        full <= 1'b0;
        intr <= inte;
      end else if (load_ev) begin
        din  <= pins;
        full <= 1'b1;
        intr <= inte;
      end else if (in_rd) begin
        full <= 1'b0;
        intr <= 1'b0;
      end
      if (inte_clr) intr <= 1'b0;
    end
  end

  // R3: output write marks the buffer full
  a_r3_write_fills: assert property (@(posedge clk) disable iff (!rst_n)
    out_wr && !cfg_clr |=> full && !intr);
  // R4: acknowledge release empties the buffer
  a_r4_ack_release: assert property (@(posedge clk) disable iff (!rst_n)
    rel_ev && !cfg_clr |=> !full);
  // R6: strobe into a full latch leaves it unchanged
  a_r6_full_holds: assert property (@(posedge clk) disable iff (!rst_n)
    dir == DIR_IN && full && hs_fall && !cfg_clr |=> $stable(din));
  // R7: CPU read of input clears flag and interrupt
  a_r7_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    in_rd && !load_ev && !cfg_clr |=> !full && !intr);
  // R8: interrupt rises only with the enable set
  a_r8_intr_gated: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(intr) |-> $past(inte));
endmodule

// File: rtl/hs_port_ctl.sv
module hs_port_ctl
  import hs_port_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] cpu_addr,
  input  logic       cpu_wr,
  input  logic       cpu_rd,
  input  logic [7:0] cpu_wdata,
  output logic [7:0] cpu_rdata,
  input  logic [7:0] a_pins_in,
  output logic [7:0] a_pins_out,
  input  logic [7:0] b_pins_in,
  output logic [7:0] b_pins_out,
  input  logic       a_stb_n,
  input  logic       a_ack_n,
  input  logic       b_hs_n,
  output logic       a_obf_n,
  output logic       a_ibf,
  output logic       a_irq,
  output logic       b_flag,
  output logic       b_irq
);
  localparam int unsigned NLINES = 3;

  dir_e dir_a, dir_b;
  logic cmd_wr, mode_wr, bsr_wr, bsr_val;
  logic [2:0] bsr_pos;
  logic [NLINES-1:0] raw, lvl, fal, ris;
  logic a_fall, a_rise;
  logic [7:0] din_a, din_b;
  logic full_a, full_b, intr_a, intr_b, inte_a, inte_b;
  logic [7:0] status;

  assign cmd_wr  = cpu_wr && (cpu_addr == ADDR_CMD);
  assign mode_wr = cmd_wr & cpu_wdata[MODE_BIT];
  assign bsr_wr  = cmd_wr & ~cpu_wdata[MODE_BIT];
  assign bsr_pos = cpu_wdata[3:1];
  assign bsr_val = cpu_wdata[0];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      dir_a <= DIR_OUT;
      dir_b <= DIR_OUT;
    end else if (mode_wr) begin
      dir_a <= dir_e'(cpu_wdata[DIR_A_BIT]);
      dir_b <= dir_e'(cpu_wdata[DIR_B_BIT]);
    end

  assign raw = {b_hs_n, a_ack_n, a_stb_n};
  for (genvar g = 0; g < NLINES; g++) begin : g_sync
    hs_port_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .async_in(raw[g]),
      .level(lvl[g]), .fall(fal[g]), .rise(ris[g]));
  end

  assign a_fall = (dir_a == DIR_IN) ? fal[0] : fal[1];
  assign a_rise = (dir_a == DIR_IN) ? ris[0] : ris[1];

  hs_port_group u_grp_a (
    .clk(clk), .rst_n(rst_n), .dir(dir_a), .cfg_clr(mode_wr),
    .inte_set(bsr_wr && bsr_val && bsr_pos == a_en_pos(dir_a)),
    .inte_clr(bsr_wr && !bsr_val && bsr_pos == a_en_pos(dir_a)),
    .cpu_wr(cpu_wr && cpu_addr == ADDR_A),
    .cpu_rd(cpu_rd && cpu_addr == ADDR_A),
    .wdata(cpu_wdata), .pins(a_pins_in),
    .hs_fall(a_fall), .hs_rise(a_rise),
    .dout(a_pins_out), .din(din_a), .full(full_a), .intr(intr_a), .inte(inte_a));

  hs_port_group u_grp_b (
    .clk(clk), .rst_n(rst_n), .dir(dir_b), .cfg_clr(mode_wr),
    .inte_set(bsr_wr && bsr_val && bsr_pos == POS_B_EN),
    .inte_clr(bsr_wr && !bsr_val && bsr_pos == POS_B_EN),
    .cpu_wr(cpu_wr && cpu_addr == ADDR_B),
    .cpu_rd(cpu_rd && cpu_addr == ADDR_B),
    .wdata(cpu_wdata), .pins(b_pins_in),
    .hs_fall(fal[2]), .hs_rise(ris[2]),
    .dout(b_pins_out), .din(din_b), .full(full_b), .intr(intr_b), .inte(inte_b));

  assign status = pack_status(dir_a, full_a, inte_a, intr_a,
                              dir_b, full_b, inte_b, intr_b);

  always_comb begin
    unique case (cpu_addr)
      ADDR_A:    cpu_rdata = (dir_a == DIR_IN) ? din_a : a_pins_out;
      ADDR_B:    cpu_rdata = (dir_b == DIR_IN) ? din_b : b_pins_out;
      ADDR_STAT: cpu_rdata = status;
      default:   cpu_rdata = '0;
    endcase
  end

  assign a_obf_n = (dir_a == DIR_OUT) ? ~full_a : 1'b1;
  assign a_ibf   = (dir_a == DIR_IN) & full_a;
  assign b_flag  = (dir_b == DIR_OUT) ? ~full_b : full_b;
  assign a_irq   = intr_a;
  assign b_irq   = intr_b;

  // R10: data write to an input-mode group keeps its output latch
  a_r10_in_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_wr && cpu_addr == ADDR_A && dir_a == DIR_IN && !mode_wr |=> $stable(a_pins_out));
  // R11: clearing the enable drops the interrupt
  a_r11_clr_drops_irq: assert property (@(posedge clk) disable iff (!rst_n)
    bsr_wr && !bsr_val && bsr_pos == POS_B_EN |=> !b_irq);
endmodule

// File: tb/hs_port_ctl_tb_top.sv
module hs_port_ctl_tb_top;
  localparam time CLK_PERIOD = 10;
  localparam int  NVEC = 6;
  // {group, enable, data}
  localparam logic [9:0] VEC [NVEC] = '{
    {1'b0, 1'b1, 8'h5A}, {1'b0, 1'b0, 8'hA5}, {1'b1, 1'b1, 8'h3C},
    {1'b1, 1'b0, 8'hFF}, {1'b0, 1'b1, 8'h00}, {1'b1, 1'b1, 8'h81}};

  logic clk = 0, rst_n = 0;
  logic [1:0] cpu_addr = 0;
  logic cpu_wr = 0, cpu_rd = 0;
  logic [7:0] cpu_wdata = 0, cpu_rdata;
  logic [7:0] a_pins_in = 0, a_pins_out, b_pins_in = 0, b_pins_out;
  logic a_stb_n = 1, a_ack_n = 1, b_hs_n = 1;
  logic a_obf_n, a_ibf, a_irq, b_flag, b_irq;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hs_port_ctl dut_i (.*);

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk);
    cpu_addr = a; cpu_wdata = d; cpu_wr = 1;
    @(negedge clk);
    cpu_wr = 0;
  endtask

  task automatic rd(logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    cpu_addr = a; cpu_rd = 1;
    #1 d = cpu_rdata;
    @(negedge clk);
    cpu_rd = 0;
  endtask

  // bit set/reset command: position in bits[3:1], value in bit0
  function automatic logic [7:0] bsr(int pos, bit v);
    return 8'((pos << 1) | int'(v));
  endfunction

  initial begin
    logic [7:0] r;
    idle(3);
    rst_n = 1;
    idle(1);
    // R1 reset state
    rd(2, r);
    check("R1 status", r, 8'h82);
    check("R1 a_obf_n", a_obf_n, 1);
    check("R1 b_flag", b_flag, 1);
    check("R1 irq", {a_irq, b_irq, a_ibf}, 0);

    // Table: output transfers on both groups
    for (int i = 0; i < NVEC; i++) begin
      bit g, en;
      logic [7:0] d;
      {g, en, d} = VEC[i];
      wr(3, bsr(g ? 2 : 6, en));
      wr(g ? 2'd1 : 2'd0, d);
      check("R3 pins", g ? b_pins_out : a_pins_out, d);
      check("R3 full low", g ? b_flag : a_obf_n, 0);
      check("R3 irq cleared", g ? b_irq : a_irq, 0);
      rd(2, r);
      check("R9 status enable", g ? r[2] : r[6], en);
      if (g) b_hs_n = 0; else a_ack_n = 0;
      idle(5);
      check("R4 held while ack low", g ? b_flag : a_obf_n, 0);
      if (g) b_hs_n = 1; else a_ack_n = 1;
      idle(5);
      check("R4 released", g ? b_flag : a_obf_n, 1);
      check("R4/R8 irq follows enable", g ? b_irq : a_irq, en);
    end

    // R2 mode word: both groups input
    wr(3, 8'h92);
    rd(2, r);
    check("R2 mode status", r, 8'h00);
    check("R2 latch cleared", b_pins_out, 0);
    // R10 write to input-mode port ignored
    wr(0, 8'h77);
    check("R10 pins unchanged", a_pins_out, 0);
    wr(3, bsr(4, 1));
    wr(3, bsr(2, 1));
    rd(2, r);
    check("R9 input enables", r, 8'h14);

    // R5 strobe load
    a_pins_in = 8'hC3;
    a_stb_n = 0;
    idle(5);
    check("R5 ibf", a_ibf, 1);
    check("R5 irq", a_irq, 1);
    rd(2, r);
    check("R9 status input full", r, 8'h3C & 8'h3C);
    a_stb_n = 1;
    idle(5);
    // R6 second strobe while full
    a_pins_in = 8'h11;
    a_stb_n = 0;
    idle(5);
    a_stb_n = 1;
    idle(5);
    rd(0, r);
    check("R6 latch kept", r, 8'hC3);
    check("R7 ibf cleared", a_ibf, 0);
    check("R7 irq cleared", a_irq, 0);

    // R8 group B input with enable clear
    wr(3, bsr(2, 0));
    b_pins_in = 8'h6E;
    b_hs_n = 0;
    idle(5);
    check("R5 b full", b_flag, 1);
    check("R8 b irq off", b_irq, 0);
    b_hs_n = 1;
    idle(5);
    rd(1, r);
    check("R7 b data", r, 8'h6E);
    check("R7 b flag cleared", b_flag, 0);

    // R11: A output, B input; pending irq dropped by enable clear
    wr(3, 8'h82);
    wr(3, bsr(6, 1));
    wr(0, 8'h42);
    a_ack_n = 0; idle(5); a_ack_n = 1; idle(5);
    check("R4 a irq", a_irq, 1);
    wr(3, bsr(6, 0));
    check("R11 irq dropped", a_irq, 0);
    // R2 unused position ignored
    wr(3, bsr(5, 1));
    rd(2, r);
    check("R2 unused bsr", r, 8'h80);
    // R4 ack while not full ignored
    a_ack_n = 0; idle(5); a_ack_n = 1; idle(5);
    check("R4 no spurious", {a_obf_n, a_irq}, 2'b10);

    // R1 reset during pending transfer
    wr(0, 8'h99);
    rst_n = 0;
    idle(2);
    rst_n = 1;
    idle(1);
    rd(2, r);
    check("R1 reset status", r, 8'h82);
    check("R1 reset pins", a_pins_out, 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule